// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps a bank of wide event counters for a 10 Gb/s Ethernet MAC. The receive and transmit classifiers drive one strobe per counter and an amount to add. Frame counters add one. Octet counters add the frame length. The counters are 40 bits wide by default. A host reaches the bank through a small word-wide register port. A control write can freeze every counter at once into holding registers, or wipe the bank.

After a snapshot, the host reads each frozen value as three 16-bit words. It also polls a clear-on-read bitmap of carry-out flags, which lets software keep totals wider than the hardware counters. The bank raises no interrupt. The host is expected to poll.

Each counter's register position comes from its index. The host therefore finds counter k at a fixed stride from a base word address. The rollover flags sit in four words below that base.

Top module: `stat_bank`

## Requirements
- R1: Counter k is read at word addresses 8+3k, 9+3k and 10+3k. The first word holds counter bits [15:0], the second bits [31:16], and the third holds bits [39:32] in its low byte with zeros above. Bits at or above the counter width read as zero.
- R2: On a clock edge where a counter's strobe is high, the counter adds its INC_W-bit amount, modulo 2^CNT_W. With the strobe low, the counter holds its value.
- R3: A write to address 0 with command bit 0 set copies every live counter into its holding register on that edge. Counter reads return only the holding registers, which stay frozen until the next snapshot.
- R4: An increment on the same edge as a snapshot lands in the live counter. It appears in the following snapshot, not the current one.
- R5: A write to address 0 with command bit 1 set zeroes all live counters, holding registers and rollover flags. This takes priority over increments and over a snapshot in the same command.
- R6: A counter's rollover flag is set on the edge where its addition carries out of CNT_W bits. Flags are read at addresses 1 to 4. Counter n maps to bit n mod 16 of address 1 + n/16. Bits with no counter behind them read zero.
- R7: Reading a rollover word returns its flags and clears them on the same edge. A carry that happens on that edge leaves its flag set.
- R8: A set rollover flag stays set through further wraps until it is read or cleared.
- R9: Read data appears on host_rdata on the edge after host_rd, with host_rvalid high for exactly that cycle. Reads of address 0 or of unmapped addresses return zero.
- R10: After synchronous reset, all counters, holding registers, flags and read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | NUM_CNT | Per-counter increment strobe |
| inc_val | input | NUM_CNT*INC_W | Per-counter amount to add; counter i uses slice i |
| host_wr | input | 1 | Host write strobe (control register only) |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wcmd | input | 2 | Command bits: bit 0 snapshot, bit 1 clear |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | High one cycle after host_rd |

## Verification
The bench drives counters across a full carry-out twice without a read in between. A design that lost sticky flags would then report no rollover. It also reads a rollover word on the same edge as a fresh carry, which catches designs that let the read-clear erase the new wrap. A snapshot issued together with an increment exposes a holding register that samples the post-increment value. A clear issued together with increments and a snapshot exposes wrong priority, which leaves stray counts behind. Reading a counter near the top of its range checks the three-word split, so a shifted or truncated upper word shows up at once.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int WORD_W        = 16;
  localparam int CTRL_ADDR     = 0;
  localparam int ROLL_BASE     = 1;
  localparam int ROLL_REGS     = 4;
  localparam int CNT_BASE      = 8;
  localparam int WORDS_PER_CNT = 3;
  localparam int MAX_CNT       = ROLL_REGS * WORD_W;
  localparam int EXT_W         = 40;
  localparam int CMD_W         = 2;
  localparam int SNAP_BIT      = 0;
  localparam int CLR_BIT       = 1;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 40,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [INC_W-1:0] amt_i,
  input  logic             wrap_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W:0] sum;

  always_comb sum = {1'b0, count_o} + (CNT_W+1)'(amt_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      count_o <= '0;
      wrap_o  <= 1'b0;
    end else begin
      if (inc_i) count_o <= sum[CNT_W-1:0];
      wrap_o <= (wrap_o & ~wrap_ack_i) | (inc_i & sum[CNT_W]);
    end
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_o == '0 && !wrap_o)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(count_o)); // R2
  AST_INC_ADDS: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i) |=> count_o == CNT_W'($past(count_o) + CNT_W'($past(amt_i)))); // R2
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !wrap_ack_i && !clr_i) |=> wrap_o); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wrap_ack_i && !inc_i && !clr_i) |=> !wrap_o); // R7
endmodule

// File: rtl/stat_hold.sv
module stat_hold #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             snap_i,
  input  logic [CNT_W-1:0] live_i,
  output logic [CNT_W-1:0] hold_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i)  hold_o <= '0;
    else if (snap_i)   hold_o <= live_i;
  end

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (snap_i && !clr_i) |=> hold_o == $past(live_i)); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!snap_i && !clr_i) |=> $stable(hold_o)); // R3
endmodule

// File: rtl/stat_host_if.sv
module stat_host_if
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 24,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [CMD_W-1:0]         host_wcmd,
  input  logic [NUM_CNT*CNT_W-1:0] hold_flat,
  input  logic [NUM_CNT-1:0]       wrap_flat,
  output logic                     snap_o,
  output logic                     clr_o,
  output logic [ROLL_REGS-1:0]     roll_ack_o,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     rvalid_o
);
  logic              ctrl_hit;
  logic [MAX_CNT-1:0] roll_vec;
  logic [WORD_W-1:0] rd_mux;
  logic [EXT_W-1:0]  ext;

  always_comb begin
    ctrl_hit = host_wr && (host_addr == ADDR_W'(CTRL_ADDR));
    snap_o   = ctrl_hit && host_wcmd[SNAP_BIT];
    clr_o    = ctrl_hit && host_wcmd[CLR_BIT];
  end

  always_comb begin
    for (int j = 0; j < ROLL_REGS; j++)
      roll_ack_o[j] = host_rd && (host_addr == ADDR_W'(ROLL_BASE + j));
  end

  always_comb roll_vec = MAX_CNT'(wrap_flat);

  always_comb begin
    rd_mux = '0;
    ext    = '0;
    for (int j = 0; j < ROLL_REGS; j++)
      if (host_addr == ADDR_W'(ROLL_BASE + j)) rd_mux = roll_vec[j*WORD_W +: WORD_W];
    for (int i = 0; i < NUM_CNT; i++) begin
      ext = EXT_W'(hold_flat[i*CNT_W +: CNT_W]);
      if (host_addr == ADDR_W'(CNT_BASE + WORDS_PER_CNT*i))     rd_mux = ext[15:0];
      if (host_addr == ADDR_W'(CNT_BASE + WORDS_PER_CNT*i + 1)) rd_mux = ext[31:16];
      if (host_addr == ADDR_W'(CNT_BASE + WORDS_PER_CNT*i + 2)) rd_mux = {8'h00, ext[39:32]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= host_rd;
      if (host_rd) rdata_o <= rd_mux;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> rvalid_o); // R9
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !rvalid_o); // R9
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(roll_ack_o)); // R7
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int NUM_CNT = 24,
  parameter int CNT_W   = 40,
  parameter int INC_W   = 16,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       inc_en,
  input  logic [NUM_CNT*INC_W-1:0] inc_val,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [CMD_W-1:0]         host_wcmd,
  output logic [WORD_W-1:0]        host_rdata,
  output logic                     host_rvalid
);
  localparam int TOP_ADDR = CNT_BASE + WORDS_PER_CNT * NUM_CNT;

  initial begin
    if (NUM_CNT > MAX_CNT || CNT_W > EXT_W || CNT_W <= 2*WORD_W || INC_W > CNT_W
        || TOP_ADDR > (1 << ADDR_W))
      $error("stat_bank: parameter set out of range");
  end

  logic                     snap, clr;
  logic [ROLL_REGS-1:0]     roll_ack;
  logic [NUM_CNT*CNT_W-1:0] live_flat;
  logic [NUM_CNT*CNT_W-1:0] hold_flat;
  logic [NUM_CNT-1:0]       wrap_flat;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .clr_i      (clr),
      .inc_i      (inc_en[i]),
      .amt_i      (inc_val[i*INC_W +: INC_W]),
      .wrap_ack_i (roll_ack[i/WORD_W]),
      .count_o    (live_flat[i*CNT_W +: CNT_W]),
      .wrap_o     (wrap_flat[i])
    );
    stat_hold #(.CNT_W(CNT_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr),
      .snap_i (snap),
      .live_i (live_flat[i*CNT_W +: CNT_W]),
      .hold_o (hold_flat[i*CNT_W +: CNT_W])
    );
  end

  stat_host_if #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_host (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wcmd  (host_wcmd),
    .hold_flat  (hold_flat),
    .wrap_flat  (wrap_flat),
    .snap_o     (snap),
    .clr_o      (clr),
    .roll_ack_o (roll_ack),
    .rdata_o    (host_rdata),
    .rvalid_o   (host_rvalid)
  );

  AST_CLR_WINS_SNAP: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hold_flat == '0 && wrap_flat == '0)); // R5
  AST_NO_WRAP_AFTER_RST: assert property (@(posedge clk)
    rst |=> (wrap_flat == '0 && host_rdata == '0)); // R10
endmodule

// File: tb/stat_bank_bench.sv
module stat_bank_bench;
  localparam int N  = 20;
  localparam int CW = 34;
  localparam int IW = 20;
  localparam int AW = 8;
  localparam logic [IW-1:0] AMAX = '1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    inc_en = '0;
  logic [N*IW-1:0] inc_val = '0;
  logic            host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [1:0]      host_wcmd = '0;
  logic [15:0]     host_rdata;
  logic            host_rvalid;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [CW-1:0] m_live [N];
  logic [CW-1:0] m_hold [N];
  logic          m_flag [N];

  always #4 clk = ~clk;

  stat_bank #(.NUM_CNT(N), .CNT_W(CW), .INC_W(IW), .ADDR_W(AW)) u_stat_bank (
    .clk(clk), .rst(rst), .inc_en(inc_en), .inc_val(inc_val),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wcmd(host_wcmd), .host_rdata(host_rdata), .host_rvalid(host_rvalid));

  function automatic logic [15:0] exp_read(input logic [AW-1:0] a);
    logic [15:0] r = '0;
    logic [39:0] e;
    for (int j = 0; j < 4; j++)
      if (a == AW'(1 + j))
        for (int b = 0; b < 16; b++)
          if (j*16 + b < N) r[b] = m_flag[j*16 + b];
    for (int i = 0; i < N; i++) begin
      e = 40'(m_hold[i]);
      if (a == AW'(8 + 3*i))     r = e[15:0];
      if (a == AW'(8 + 3*i + 1)) r = e[31:16];
      if (a == AW'(8 + 3*i + 2)) r = {8'h00, e[39:32]};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [N-1:0] en, input logic [N*IW-1:0] amt,
                          input logic wr, input logic rd, input logic [AW-1:0] a,
                          input logic [1:0] cmd, input string req);
    logic [15:0] exp;
    logic        clr, snap;
    logic [CW:0] sum;
    inc_en = en; inc_val = amt; host_wr = wr; host_rd = rd; host_addr = a; host_wcmd = cmd;
    exp  = exp_read(a);
    clr  = wr && a == '0 && cmd[1];
    snap = wr && a == '0 && cmd[0];
    for (int i = 0; i < N; i++) begin
      sum = {1'b0, m_live[i]} + (en[i] ? (CW+1)'(amt[i*IW +: IW]) : '0);
      if (clr) begin
        m_live[i] = '0; m_hold[i] = '0; m_flag[i] = 1'b0;
      end else begin
        if (snap) m_hold[i] = m_live[i];
        m_flag[i] = (m_flag[i] && !(rd && a == AW'(1 + i/16))) || (en[i] && sum[CW]);
        m_live[i] = sum[CW-1:0];
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (rd) begin
      check({req, " rvalid"}, {15'd0, host_rvalid}, 16'd1);
      check(req, host_rdata, exp);
    end
    inc_en = '0; host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    do_cycle('0, '0, 1'b0, 1'b1, a, 2'b00, req);
  endtask

  task automatic cmd(input logic [1:0] c, input string req);
    do_cycle('0, '0, 1'b1, 1'b0, '0, c, req);
  endtask

  function automatic logic [N*IW-1:0] one_amt(input int idx, input logic [IW-1:0] v);
    logic [N*IW-1:0] r = '0;
    r[idx*IW +: IW] = v;
    return r;
  endfunction

  initial begin
    logic [N-1:0]    en;
    logic [N*IW-1:0] amt;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_live[i] = '0; m_hold[i] = '0; m_flag[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state, R9 unmapped and control reads
    check("R10 rvalid idle", {15'd0, host_rvalid}, 16'd0);
    for (int j = 1; j <= 4; j++) rd(AW'(j), "R10 rollover after reset");
    rd(AW'(8), "R10 counter after reset");
    rd(AW'(0), "R9 control reads zero");
    rd(AW'(5), "R9 unmapped reads zero");
    rd(AW'(8 + 3*N), "R9 past last counter reads zero");

    // R2/R3/R1 random traffic with snapshots; reads run while counters keep moving
    for (int round = 0; round < 4; round++) begin
      for (int c = 0; c < 150; c++) begin
        en = N'({$urandom, $urandom});
        for (int i = 0; i < N; i++) amt[i*IW +: IW] = (c % 3 == 0) ? IW'(1) : IW'($urandom);
        do_cycle(en, amt, 1'b0, 1'b0, '0, 2'b00, "R2 traffic");
      end
      cmd(2'b01, "R3 snapshot");
      for (int a = 8; a < 8 + 3*N; a++) begin
        en = N'({$urandom, $urandom});
        for (int i = 0; i < N; i++) amt[i*IW +: IW] = IW'($urandom);
        do_cycle(en, amt, 1'b0, 1'b1, AW'(a), 2'b00, "R3 R1 frozen counter read");
      end
      rd(AW'(1), "R6 no rollover yet");
    end

    // R4 increment in the snapshot cycle goes to the next snapshot
    do_cycle(N'(1), one_amt(0, IW'(5)), 1'b1, 1'b0, '0, 2'b01, "R4 snap with inc");
    rd(AW'(8), "R4 snapshot excludes same-cycle increment");
    cmd(2'b01, "R4 second snapshot");
    rd(AW'(8), "R4 next snapshot includes increment");

    // R5 clear beats increments and a same-command snapshot
    do_cycle('1, {N{IW'(7)}}, 1'b1, 1'b0, '0, 2'b11, "R5 clear with inc");
    for (int a = 8; a < 8 + 3*N; a += 3) rd(AW'(a), "R5 holding cleared");
    cmd(2'b01, "R5 snapshot after clear");
    for (int a = 8; a < 8 + 3*N; a++) rd(AW'(a), "R5 live cleared");

    // R6/R8 counters 3 and 17 wrap twice before any read
    begin
      int wraps = 0;
      logic [CW-1:0] prev;
      while (wraps < 2) begin
        prev = m_live[3];
        do_cycle(N'(1) << 3 | N'(1) << 17, one_amt(3, AMAX) | one_amt(17, AMAX),
                 1'b0, 1'b0, '0, 2'b00, "R6 drive wrap");
        if (m_live[3] < prev) wraps++;
      end
    end
    rd(AW'(1), "R6 R8 rollover word 1 after double wrap");
    rd(AW'(2), "R6 rollover word 2 counter 17 bit 1");
    rd(AW'(1), "R7 word 1 cleared by read");
    rd(AW'(2), "R7 word 2 cleared by read");

    // R7 read of a rollover word on the very edge of a fresh carry
    cmd(2'b10, "R7 clear before test");
    while ({1'b0, m_live[5]} + (CW+1)'(AMAX) < (CW+1)'(1) << CW)
      do_cycle(N'(1) << 5, one_amt(5, AMAX), 1'b0, 1'b0, '0, 2'b00, "R7 drive near wrap");
    cmd(2'b01, "R1 snapshot near top");
    rd(AW'(8 + 15), "R1 low word near top");
    rd(AW'(8 + 16), "R1 middle word near top");
    rd(AW'(8 + 17), "R1 upper word near top");
    do_cycle(N'(1) << 5, one_amt(5, AMAX), 1'b0, 1'b1, AW'(1), 2'b00, "R7 read during wrap");
    rd(AW'(1), "R7 wrap on read edge stays set");
    rd(AW'(1), "R7 cleared afterwards");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule